// File: doc/BRIEF.md
# Read Completion Splitter

The splitter takes one accepted memory read request and turns it into the ordered list of completion descriptors that carry the data back to the requester. A request gives a doubleword-aligned start address, a length in doublewords and the enables of its first and last doublewords. Each descriptor gives the address of the piece, how many doublewords it carries, how many bytes of the request are still outstanding when that piece is sent, and whether it is the final piece.

Pieces are cut only on addresses aligned to the configured completion boundary, either 64 or 128 bytes. No piece may carry more than the configured maximum payload. Within those limits the splitter makes each piece as long as it can. A read of one doubleword with no byte enabled still returns one doubleword. Requests enter on a valid/ready handshake and descriptors leave on a second one. The block holds one request at a time, so the next request waits until the last descriptor of the current one has been taken.

Top module: `rd_cpl_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `cpl_valid` is 0.
- R2: The first descriptor's `cpl_addr` is the request's doubleword address with bits [1:0] set to the index of the lowest set bit of `req_first_be`, or 0 if no bit is set. Every later descriptor has bits [1:0] equal to 0.
- R3: Every descriptor after the first begins on an address aligned to the completion boundary. `cfg_rcb_sel` = 0 selects 64 bytes and 1 selects 128 bytes.
- R4: No descriptor has `cpl_len_dw` of 0 or greater than the maximum payload. `cfg_mps_sel` = n selects 128·2^n bytes, for n from 0 to 3.
- R5: The first piece ends at the furthest boundary-aligned address that keeps it within the maximum payload. Each later piece is max-payload long, except the final piece, which takes what remains. A request that fits this way produces exactly one descriptor.
- R6: Descriptors of one request come out in strictly increasing address order. Their lengths add up to the request length, and `cpl_last` is 1 only on the final one.
- R7: `cpl_byte_cnt` is the number of bytes still to be returned, including the current piece. The request total is 4·len, minus the unset bits below the lowest set bit of `req_first_be`, minus the unset bits above the highest set bit of `req_last_be`. For a one-doubleword read, the total is the span from the lowest to the highest set bit of `req_first_be`.
- R8: A read with `req_len_dw` = 1 and `req_first_be` = 0000 gives one descriptor with length 1, byte count 1 and address bits [1:0] = 0.
- R9: While `cpl_valid` is 1 and `cpl_ready` is 0, every descriptor output holds its value into the next cycle.
- R10: `req_ready` goes low in the cycle after a request is accepted. It stays low until the last descriptor is taken and is 1 again in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rcb_sel | input | 1 | Completion boundary: 0 = 64 B, 1 = 128 B |
| cfg_mps_sel | input | 2 | Maximum payload code n, 128·2^n bytes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Splitter idle and able to take a request |
| req_addr | input | ADDR_W | Request byte address (bits [1:0] ignored) |
| req_len_dw | input | LEN_W | Request length in doublewords, nonzero |
| req_first_be | input | 4 | Byte enables of the first doubleword |
| req_last_be | input | 4 | Byte enables of the last doubleword (0 when length is 1) |
| cpl_valid | output | 1 | Descriptor present |
| cpl_ready | input | 1 | Consumer takes the descriptor |
| cpl_addr | output | ADDR_W | Byte address of the piece |
| cpl_len_dw | output | LEN_W | Doublewords in the piece |
| cpl_byte_cnt | output | LEN_W+2 | Bytes still outstanding, including this piece |
| cpl_last | output | 1 | Final piece of the request |

## Verification
The bench covers these cases. A request that starts one doubleword below a 128-byte boundary must split into two one-doubleword pieces; a cut off by one would cross the boundary or merge the pieces. A range that crosses a 64-byte boundary but fits in one payload must stay a single piece; an over-eager cutter would split it. The zero-enable read must report byte count 1, and mixed partial enables must subtract the right skipped bytes; a wrong skip count shows up as a byte-count error on every following piece. A 4 KB request at a 512-byte payload, consumed under irregular backpressure, catches descriptors that change while stalled and `req_ready` rising early.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  // Index of the lowest enabled byte lane; 0 when no lane is enabled.
  function automatic logic [1:0] be_lead(input logic [3:0] be);
    casez (be)
      4'b???1: be_lead = 2'd0;
      4'b??10: be_lead = 2'd1;
      4'b?100: be_lead = 2'd2;
      4'b1000: be_lead = 2'd3;
      default: be_lead = 2'd0;
    endcase
  endfunction

  // Count of disabled lanes above the highest enabled lane.
  function automatic logic [1:0] be_tail(input logic [3:0] be);
    casez (be)
      4'b1???: be_tail = 2'd0;
      4'b01??: be_tail = 2'd1;
      4'b001?: be_tail = 2'd2;
      4'b0001: be_tail = 2'd3;
      default: be_tail = 2'd0;
    endcase
  endfunction

  // Maximum payload in doublewords for a code: 32 << code.
  function automatic int unsigned mps_dw_of(input logic [1:0] code);
    mps_dw_of = 32 << code;
  endfunction

  // Completion boundary in doublewords.
  function automatic int unsigned blk_dw_of(input logic sel);
    blk_dw_of = sel ? 32 : 16;
  endfunction

endpackage

// File: rtl/rcs_bytes.sv
module rcs_bytes #(
  parameter int LEN_W = 11,
  localparam int BC_W = LEN_W + 2
) (
  input  logic [LEN_W-1:0] len_dw,
  input  logic [3:0]       first_be,
  input  logic [3:0]       last_be,
  output logic [BC_W-1:0]  total_bytes,
  output logic [1:0]       lead_off
);
  import rcs_pkg::*;

  logic [BC_W-1:0] raw_bytes;
  logic [2:0]      span;

  always_comb begin
    raw_bytes = {len_dw, 2'b00};
    lead_off  = be_lead(first_be);
    span      = 3'd4 - {1'b0, be_lead(first_be)} - {1'b0, be_tail(first_be)};
    if (len_dw == LEN_W'(1)) begin
      // single doubleword: span of first enables, zero enables -> 1 byte
      total_bytes = (first_be == 4'b0000) ? BC_W'(1) : BC_W'(span);
    end else begin
      total_bytes = raw_bytes - BC_W'(be_lead(first_be)) - BC_W'(be_tail(last_be));
    end
  end

endmodule

// File: rtl/rcs_cut.sv
module rcs_cut #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  localparam int DWA_W = ADDR_W - 2
) (
  input  logic [DWA_W-1:0] cur_dw,
  input  logic [LEN_W-1:0] rem_dw,
  input  logic             rcb_sel,
  input  logic [1:0]       mps_sel,
  output logic [LEN_W-1:0] piece_dw,
  output logic [LEN_W-1:0] blk_dw,
  output logic [LEN_W-1:0] mps_dw
);
  import rcs_pkg::*;

  logic [LEN_W-1:0] blk_off;
  logic [LEN_W-1:0] room_dw;

  always_comb begin
    blk_dw   = LEN_W'(blk_dw_of(rcb_sel));
    mps_dw   = LEN_W'(mps_dw_of(mps_sel));
    // offset of the current doubleword inside its completion block
    blk_off  = LEN_W'(cur_dw[5:0]) & (blk_dw - LEN_W'(1));
    // the payload cap is a whole number of blocks, so this ends on a boundary
    room_dw  = mps_dw - blk_off;
    piece_dw = (rem_dw < room_dw) ? rem_dw : room_dw;
  end

endmodule

// File: rtl/rd_cpl_splitter.sv
module rd_cpl_splitter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  localparam int BC_W  = LEN_W + 2,
  localparam int DWA_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rcb_sel,
  input  logic [1:0]        cfg_mps_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len_dw,
  input  logic [3:0]        req_first_be,
  input  logic [3:0]        req_last_be,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [ADDR_W-1:0] cpl_addr,
  output logic [LEN_W-1:0]  cpl_len_dw,
  output logic [BC_W-1:0]   cpl_byte_cnt,
  output logic              cpl_last
);

  logic             busy_q;
  logic             first_q;
  logic [DWA_W-1:0] cur_dw_q;
  logic [LEN_W-1:0] rem_dw_q;
  logic [BC_W-1:0]  rem_bytes_q;
  logic [1:0]       lead_q;

  logic [BC_W-1:0]  req_total;
  logic [1:0]       req_lead;
  logic [LEN_W-1:0] piece_dw;
  logic [LEN_W-1:0] blk_dw_w;
  logic [LEN_W-1:0] mps_dw_w;

  // named events for the checks
  logic             req_fire;
  logic             cut_fire;
  logic             final_fire;
  logic [ADDR_W-1:0] blk_mask_w;

  rcs_bytes #(.LEN_W(LEN_W)) u_bytes (
    .len_dw      (req_len_dw),
    .first_be    (req_first_be),
    .last_be     (req_last_be),
    .total_bytes (req_total),
    .lead_off    (req_lead)
  );

  rcs_cut #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cut (
    .cur_dw   (cur_dw_q),
    .rem_dw   (rem_dw_q),
    .rcb_sel  (cfg_rcb_sel),
    .mps_sel  (cfg_mps_sel),
    .piece_dw (piece_dw),
    .blk_dw   (blk_dw_w),
    .mps_dw   (mps_dw_w)
  );

  assign req_ready    = !busy_q;
  assign cpl_valid    = busy_q;
  assign cpl_addr     = {cur_dw_q, (first_q ? lead_q : 2'b00)};
  assign cpl_len_dw   = piece_dw;
  assign cpl_byte_cnt = rem_bytes_q;
  assign cpl_last     = (piece_dw == rem_dw_q);

  assign req_fire   = req_valid && req_ready;
  assign cut_fire   = cpl_valid && cpl_ready;
  assign final_fire = cut_fire && cpl_last;
  assign blk_mask_w = ADDR_W'({blk_dw_w, 2'b00}) - ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      first_q     <= 1'b0;
      cur_dw_q    <= '0;
      rem_dw_q    <= '0;
      rem_bytes_q <= '0;
      lead_q      <= 2'b00;
    end else if (req_fire) begin
      busy_q      <= 1'b1;
      first_q     <= 1'b1;
      cur_dw_q    <= req_addr[ADDR_W-1:2];
      rem_dw_q    <= req_len_dw;
      rem_bytes_q <= req_total;
      lead_q      <= req_lead;
    end else if (cut_fire) begin
      first_q     <= 1'b0;
      cur_dw_q    <= cur_dw_q + DWA_W'(piece_dw);
      rem_dw_q    <= rem_dw_q - piece_dw;
      rem_bytes_q <= rem_bytes_q - BC_W'({piece_dw, 2'b00})
                     + (first_q ? BC_W'(lead_q) : BC_W'(0));
      if (cpl_last) busy_q <= 1'b0;
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !cpl_valid)); // R1

  AST_LATER_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !first_q) |-> (cpl_addr[1:0] == 2'b00)); // R2

  AST_CUT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !first_q) |-> ((cpl_addr & blk_mask_w) == '0)); // R3

  AST_PAYLOAD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (cpl_len_dw != '0 && cpl_len_dw <= mps_dw_w)); // R4

  AST_ADDR_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_fire && !cpl_last) |=> (cpl_valid && cpl_addr > $past(cpl_addr))); // R6

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_addr) && $stable(cpl_len_dw)
      && $stable(cpl_byte_cnt) && $stable(cpl_last))); // R9

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (!req_ready && cpl_valid)); // R10

  AST_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    final_fire |=> req_ready); // R10

endmodule

// File: tb/sim_rd_cpl_splitter.sv
module sim_rd_cpl_splitter;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 11;
  localparam int BC_W   = LEN_W + 2;

  typedef struct packed {
    logic [31:0] addr;
    logic [10:0] len;
    logic [3:0]  fbe;
    logic [3:0]  lbe;
    logic        rcb;
    logic [1:0]  mps;
    logic [7:0]  n_exp;
    logic [12:0] tot_exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 11'd1,    4'hF, 4'h0, 1'b1, 2'd0, 8'd1, 13'd4},    // R1 R5 full DW
    '{32'h0000_1004, 11'd1,    4'h0, 4'h0, 1'b1, 2'd0, 8'd1, 13'd1},    // R8 zero byte
    '{32'h0000_00F0, 11'd8,    4'hE, 4'h3, 1'b0, 2'd0, 8'd1, 13'd29},   // R5 crosses, fits
    '{32'h0000_0040, 11'd64,   4'hF, 4'hF, 1'b1, 2'd0, 8'd3, 13'd256},  // R3 R5
    '{32'h0000_0000, 11'd100,  4'hF, 4'hF, 1'b0, 2'd1, 8'd2, 13'd400},  // R4
    '{32'h0000_001C, 11'd40,   4'hC, 4'h1, 1'b0, 2'd0, 8'd2, 13'd155},  // R7
    '{32'h0000_0000, 11'd1024, 4'hF, 4'hF, 1'b1, 2'd2, 8'd8, 13'd4096}, // R6 R9
    '{32'h0000_007C, 11'd2,    4'h8, 4'h1, 1'b1, 2'd0, 8'd2, 13'd2}     // R3 one below
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_rcb_sel = 1'b0;
  logic [1:0]        cfg_mps_sel = 2'd0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len_dw = '0;
  logic [3:0]        req_first_be = 4'h0;
  logic [3:0]        req_last_be = 4'h0;
  logic              cpl_valid;
  logic              cpl_ready = 1'b0;
  logic [ADDR_W-1:0] cpl_addr;
  logic [LEN_W-1:0]  cpl_len_dw;
  logic [BC_W-1:0]   cpl_byte_cnt;
  logic              cpl_last;

  int checks = 0;
  int fails  = 0;
  int tick   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) tick <= tick + 1;

  rd_cpl_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (
    .clk, .rst_n, .cfg_rcb_sel, .cfg_mps_sel, .req_valid, .req_ready,
    .req_addr, .req_len_dw, .req_first_be, .req_last_be,
    .cpl_valid, .cpl_ready, .cpl_addr, .cpl_len_dw, .cpl_byte_cnt, .cpl_last
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at tick %0d", req, act, exp, tick);
    end
  endtask

  // Byte count of a request restated by counting lanes.
  function automatic int bench_total(input int len, input logic [3:0] f, input logic [3:0] l);
    int lo = -1, hi = -1, lo_f = 4, hi_l = -1;
    for (int b = 0; b < 4; b++) if (f[b]) begin if (lo < 0) lo = b; hi = b; end
    if (len == 1) return (lo < 0) ? 1 : hi - lo + 1;
    for (int b = 0; b < 4; b++) begin
      if (f[b] && lo_f == 4) lo_f = b;
      if (l[b]) hi_l = b;
    end
    return len * 4 - lo_f - (3 - hi_l);
  endfunction

  function automatic int bench_lead(input logic [3:0] f);
    for (int b = 0; b < 4; b++) if (f[b]) return b;
    return 0;
  endfunction

  task automatic run_req(input vec_t v, input int stall_seed);
    int cur_b, rem_dw, rem_b, blk_b, mps_b, exp_len, n, sent_dw, room;
    logic [ADDR_W-1:0] exp_addr;
    logic [ADDR_W-1:0] hold_addr;
    logic [LEN_W-1:0]  hold_len;
    logic [BC_W-1:0]   hold_bc;
    bit                stalled;
    @(negedge clk);
    cfg_rcb_sel = v.rcb; cfg_mps_sel = v.mps;
    chk(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
    req_addr = v.addr; req_len_dw = v.len; req_first_be = v.fbe; req_last_be = v.lbe;
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready drops after accept", req_ready, 0);
    cur_b  = int'(v.addr) & ~3;
    rem_dw = int'(v.len);
    rem_b  = bench_total(int'(v.len), v.fbe, v.lbe);
    chk(rem_b == int'(v.tot_exp), "R7 table total", rem_b, v.tot_exp);
    blk_b  = v.rcb ? 128 : 64;
    mps_b  = 128 << v.mps;
    n = 0; sent_dw = 0;
    forever begin
      if (!cpl_valid || done) begin
        chk(1'b0, "R6 descriptor missing", cpl_valid, 1);
        break;
      end
      room     = mps_b - (cur_b % blk_b);
      exp_len  = (rem_dw * 4 < room) ? rem_dw : room / 4;
      exp_addr = ADDR_W'(cur_b + ((n == 0) ? bench_lead(v.fbe) : 0));
      stalled  = (((n + stall_seed) % 3) == 1);
      if (stalled) begin
        cpl_ready = 1'b0;
        hold_addr = cpl_addr; hold_len = cpl_len_dw; hold_bc = cpl_byte_cnt;
        @(posedge clk); @(negedge clk);
        chk(cpl_valid && cpl_addr == hold_addr && cpl_len_dw == hold_len
            && cpl_byte_cnt == hold_bc, "R9 held under stall", cpl_addr, hold_addr);
      end
      chk(cpl_addr == exp_addr, "R2 R3 piece address", cpl_addr, exp_addr);
      chk(int'(cpl_len_dw) == exp_len, "R4 R5 piece length", cpl_len_dw, exp_len);
      chk(int'(cpl_byte_cnt) == rem_b, "R7 R8 byte count", cpl_byte_cnt, rem_b);
      chk(cpl_last == (exp_len == rem_dw), "R6 last flag", cpl_last, exp_len == rem_dw);
      chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
      cpl_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      cpl_ready = 1'b0;
      rem_b   -= exp_len * 4 - ((n == 0) ? bench_lead(v.fbe) : 0);
      cur_b   += exp_len * 4;
      rem_dw  -= exp_len;
      sent_dw += exp_len;
      n++;
      if (rem_dw <= 0) break;
    end
    chk(n == int'(v.n_exp), "R5 R6 piece count", n, v.n_exp);
    chk(sent_dw == int'(v.len), "R6 lengths sum", sent_dw, v.len);
    chk(req_ready == 1'b1 && cpl_valid == 1'b0, "R10 free after last", req_ready, 1);
  endtask

  initial begin
    #5;
    chk(req_ready == 1'b1 && cpl_valid == 1'b0, "R1 reset state", cpl_valid, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk(req_ready == 1'b1 && cpl_valid == 1'b0, "R1 after release", cpl_valid, 0);
    for (int i = 0; i < NV; i++) run_req(VECS[i], i);
    // directed: zero-byte read at an odd doubleword, consumed without stalls (R8)
    run_req('{32'h0000_0FFC, 11'd1, 4'h0, 4'h0, 1'b0, 2'd3, 8'd1, 13'd1}, 2);
    // directed: request valid held high during busy is not taken early (R10)
    @(negedge clk);
    cfg_rcb_sel = 1'b0; cfg_mps_sel = 2'd0;
    req_addr = 32'h0000_0000; req_len_dw = 11'd64; req_first_be = 4'hF; req_last_be = 4'hF;
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(cpl_valid && cpl_len_dw == 11'd32, "R4 first of two", cpl_len_dw, 32);
    repeat (2) begin @(posedge clk); @(negedge clk); end
    chk(cpl_addr == 32'h0 && cpl_byte_cnt == 13'd256, "R9 R10 no re-accept while busy",
        cpl_byte_cnt, 256);
    req_valid = 1'b0;
    cpl_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(cpl_addr == 32'h80 && cpl_last && cpl_byte_cnt == 13'd128, "R3 R7 second piece",
        cpl_addr, 32'h80);
    @(posedge clk); @(negedge clk);
    cpl_ready = 1'b0;
    chk(req_ready && !cpl_valid, "R10 idle at end", req_ready, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", tick, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule